// File: doc/BRIEF.md
# Change-Triggered Interrupt Message Aggregator

This block gathers eleven interrupt request lines and turns activity on them into one outbound posted-write message for a processor. Each line passes through a two-stage synchronizer. A change on a line, rising or falling, is recorded when that line is enabled. A recorded change on an implemented line raises a message request. The message carries a data word and a destination address, both taken from one programmed target word.

Software works the block through a small register window with word offsets. It programs the target word, the enable mask and a control word. It reads the request register to acknowledge, and that read clears the register. It reads the pending register, which also clears on read. It reads a live-level register to see which lines are still asserted. A line held asserted produces no further message. A handler that wants level behaviour re-reads the live level after it has serviced the requests.

Only one message is outstanding at a time. A message stays valid until the carrier acknowledges it. Any enabled changes that arrive in the meantime are folded into a single follow-up message.

Top module: `irq_agg`

## Requirements
- R1: The live-level register at offset 0x028 returns the input lines two clock edges after they are driven, whatever the mask, pending and request state.
- R2: A change on a line whose mask bit is 1 sets that line's pending bit. It also sets the line's request bit, but only for lines in the implemented set 0x5FF. A change on line 9 therefore sets pending and never request, and launches no message. Changes on lines whose mask bit is 0 set nothing.
- R3: A read of the request register (0x00C) or the pending register (0x01C) returns its value and clears it at that clock edge. Neither read alters the live level.
- R4: When control bit 0 (offset 0x024) is 1, a change that sets a new request bit raises `msg_valid` on the third clock edge after the input moves. This holds for both rising and falling changes. `msg_addr` is the target word (offset 0x004) with its low 5 bits cleared, and `msg_data` is those low 5 bits, zero-extended.
- R5: A line that is already asserted when its mask bit is set to 1 produces no request and no message.
- R6: While `msg_valid` is 1 and `msg_ack` is 0, `msg_valid`, `msg_addr` and `msg_data` hold their values.
- R7: Changes that arrive while a message is outstanding are merged into exactly one follow-up message. `msg_valid` goes low for one cycle after the acknowledge, then rises again.
- R8: After reset, the mask, pending, request, control and target registers read 0, and `msg_valid` is 0.
- R9: While control bit 0 is 0, no message is launched, but pending and request still latch. Setting the bit later does not by itself produce a message.
- R10: The mask register is at offset 0x018 and the target at 0x004; both read back what was written. Writes to the request, pending and live-level offsets have no effect. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 11 | Asynchronous interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects at the edge) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| msg_valid | output | 1 | Outbound message request |
| msg_ack | input | 1 | Message accepted by the carrier |
| msg_addr | output | 32 | Message destination address |
| msg_data | output | 32 | Message data word |

## Verification
The bench builds the block with its defaults: eleven lines, implemented set 0x5FF, and a 5-bit data field inside the target word. With eleven lines, both the unimplemented line 9 and the top line 10 can be driven. The 0x5FF set lets one stimulus show pending and request diverging. The 5-bit field puts a visible split between address and data into a single programmed word, so both halves of a message can be checked at once.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int REG_AW = 12;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] OFF_TARGET = 12'h004;
    localparam logic [REG_AW-1:0] OFF_REQ    = 12'h00C;
    localparam logic [REG_AW-1:0] OFF_MASK   = 12'h018;
    localparam logic [REG_AW-1:0] OFF_PEND   = 12'h01C;
    localparam logic [REG_AW-1:0] OFF_CTRL   = 12'h024;
    localparam logic [REG_AW-1:0] OFF_LEVEL  = 12'h028;

    localparam int CTRL_EN_BIT = 0;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int N_LINES = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines_i,
    output logic [N_LINES-1:0] level_o,
    output logic [N_LINES-1:0] change_o
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic meta_q, stab_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= lines_i[i];
                stab_q <= meta_q;
                prev_q <= stab_q;
            end
        end

        assign level_o[i]  = stab_q;
        assign change_o[i] = stab_q ^ prev_q;
    end
endmodule

// File: rtl/irq_agg_launch.sv
module irq_agg_launch #(
    parameter int MSG_DATA_W = 5,
    parameter int WORD_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              en_i,
    input  logic [WORD_W-1:0] target_i,
    input  logic              ack_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] addr_o,
    output logic [WORD_W-1:0] data_o
);
    localparam logic [WORD_W-1:0] FIELD_MASK = WORD_W'((64'd1 << MSG_DATA_W) - 64'd1);

    typedef struct packed {
        logic              busy;
        logic              merge;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } launch_t;

    launch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (ack_i) begin
                st_d.busy = 1'b0;
            end
            if (fire_i) begin
                st_d.merge = 1'b1;
            end
        end else if (en_i && (fire_i || st_q.merge)) begin
            st_d.busy  = 1'b1;
            st_d.merge = 1'b0;
            st_d.addr  = target_i & ~FIELD_MASK;
            st_d.data  = target_i & FIELD_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.busy;
    assign addr_o  = st_q.addr;
    assign data_o  = st_q.data;
endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int                 N_LINES    = 11,
    parameter logic [N_LINES-1:0] IMPL_MASK  = 11'h5FF,
    parameter int                 MSG_DATA_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [REG_DW-1:0]  reg_wdata,
    output logic [REG_DW-1:0]  reg_rdata,
    output logic               msg_valid,
    input  logic               msg_ack,
    output logic [REG_DW-1:0]  msg_addr,
    output logic [REG_DW-1:0]  msg_data
);
    localparam int PAD_W = REG_DW - N_LINES;

    typedef struct packed {
        logic [REG_DW-1:0]  target;
        logic [N_LINES-1:0] mask;
        logic [N_LINES-1:0] pend;
        logic [N_LINES-1:0] req;
        logic               ctrl_en;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [N_LINES-1:0] level;
    logic [N_LINES-1:0] change;
    logic [N_LINES-1:0] new_pend;
    logic [N_LINES-1:0] new_req;
    logic               fire;
    logic [N_LINES-1:0] req_w;
    logic               ctrl_en_w;

    irq_agg_sync #(.N_LINES(N_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_i  (irq_in),
        .level_o  (level),
        .change_o (change)
    );

    assign new_pend  = change & regs_q.mask;
    assign new_req   = new_pend & IMPL_MASK;
    assign fire      = regs_q.ctrl_en && (new_req != '0);
    assign req_w     = regs_q.req;
    assign ctrl_en_w = regs_q.ctrl_en;

    always_comb begin
        regs_d = regs_q;

        if (reg_rd && reg_addr == OFF_REQ) begin
            regs_d.req = '0;
        end
        if (reg_rd && reg_addr == OFF_PEND) begin
            regs_d.pend = '0;
        end
        regs_d.req  = regs_d.req | new_req;
        regs_d.pend = regs_d.pend | new_pend;

        if (reg_wr) begin
            case (reg_addr)
                OFF_TARGET: regs_d.target  = reg_wdata;
                OFF_MASK:   regs_d.mask    = reg_wdata[N_LINES-1:0];
                OFF_CTRL:   regs_d.ctrl_en = reg_wdata[CTRL_EN_BIT];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_TARGET: reg_rdata = regs_q.target;
            OFF_REQ:    reg_rdata = {{PAD_W{1'b0}}, regs_q.req};
            OFF_MASK:   reg_rdata = {{PAD_W{1'b0}}, regs_q.mask};
            OFF_PEND:   reg_rdata = {{PAD_W{1'b0}}, regs_q.pend};
            OFF_CTRL:   reg_rdata[CTRL_EN_BIT] = regs_q.ctrl_en;
            OFF_LEVEL:  reg_rdata = {{PAD_W{1'b0}}, level};
            default:    reg_rdata = '0;
        endcase
    end

    irq_agg_launch #(
        .MSG_DATA_W (MSG_DATA_W),
        .WORD_W     (REG_DW)
    ) u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .en_i     (regs_q.ctrl_en),
        .target_i (regs_q.target),
        .ack_i    (msg_ack),
        .valid_o  (msg_valid),
        .addr_o   (msg_addr),
        .data_o   (msg_data)
    );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int                 N_LINES   = 11,
    parameter logic [N_LINES-1:0] IMPL_MASK = 11'h5FF
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_rd,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [REG_DW-1:0]  reg_rdata,
    input logic               msg_valid,
    input logic               msg_ack,
    input logic [REG_DW-1:0]  msg_addr,
    input logic [REG_DW-1:0]  msg_data,
    input logic [N_LINES-1:0] req_w,
    input logic [N_LINES-1:0] new_req,
    input logic               ctrl_en_w
);
    // R6: an unacknowledged message is held unchanged
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R7: an accepted message drops for one cycle before any follow-up
    p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ack) |=> !msg_valid);

    // R9: a message only starts while the control enable is set
    p_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(ctrl_en_w));

    // R2: unimplemented lines never appear in the request register
    p_impl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_REQ) |-> ((reg_rdata[N_LINES-1:0] & ~IMPL_MASK) == '0));

    // R3: a request read with no new request leaves the register empty
    p_rdclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_REQ && new_req == '0) |=> (req_w == '0));
endmodule

bind irq_agg irq_agg_chk #(
    .N_LINES   (N_LINES),
    .IMPL_MASK (IMPL_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .msg_valid (msg_valid),
    .msg_ack   (msg_ack),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .req_w     (req_w),
    .new_req   (new_req),
    .ctrl_en_w (ctrl_en_w)
);

// File: tb/irq_agg_tb.sv
`timescale 1ns/1ps
module irq_agg_tb;
    import irq_agg_pkg::*;

    localparam int N = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          msg_valid;
    logic          msg_ack = 1'b0;
    logic [31:0]   msg_addr;
    logic [31:0]   msg_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_agg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .msg_valid (msg_valid),
        .msg_ack   (msg_ack),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        reg_rd = 1'b1;
        reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ack_once();
        msg_ack = 1'b1;
        @(negedge clk);
        msg_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R8 msg_valid", {31'd0, msg_valid}, 32'd0);
        rd(OFF_MASK, v);   chk("R8 mask", v, 32'd0);
        rd(OFF_PEND, v);   chk("R8 pending", v, 32'd0);
        rd(OFF_REQ, v);    chk("R8 request", v, 32'd0);
        rd(OFF_CTRL, v);   chk("R8 control", v, 32'd0);
        rd(OFF_TARGET, v); chk("R8 target", v, 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        irq_in = 11'h0A5;
        tick(2);
        rd(OFF_LEVEL, v); chk("R1 level follows lines", v, 32'h0A5);
        rd(OFF_PEND, v);  chk("R2 masked lines leave pending", v, 32'd0);
        rd(OFF_REQ, v);   chk("R2 masked lines leave request", v, 32'd0);
        chk("R2 masked no message", {31'd0, msg_valid}, 32'd0);
        irq_in = '0;
        tick(4);
        rd(OFF_LEVEL, v); chk("R1 level returns low", v, 32'd0);
    endtask

    task automatic t_message();
        logic [31:0] v;
        wr(OFF_TARGET, 32'h1234_5A13);
        wr(OFF_CTRL, 32'd1);
        wr(OFF_MASK, 32'h7FF);
        irq_in = 11'h008;
        tick(2);
        chk("R4 no message before third edge", {31'd0, msg_valid}, 32'd0);
        tick(1);
        chk("R4 message on third edge", {31'd0, msg_valid}, 32'd1);
        chk("R4 address", msg_addr, 32'h1234_5A00);
        chk("R4 data", msg_data, 32'h0000_0013);
        tick(1);
        chk("R6 held without ack", {31'd0, msg_valid}, 32'd1);
        chk("R6 address held", msg_addr, 32'h1234_5A00);
        rd(OFF_REQ, v);   chk("R3 request read value", v, 32'h008);
        rd(OFF_REQ, v);   chk("R3 request cleared", v, 32'd0);
        rd(OFF_PEND, v);  chk("R3 pending read value", v, 32'h008);
        rd(OFF_PEND, v);  chk("R3 pending cleared", v, 32'd0);
        rd(OFF_LEVEL, v); chk("R3 level untouched by reads", v, 32'h008);
        ack_once();
        chk("R4 valid drops after ack", {31'd0, msg_valid}, 32'd0);
        irq_in = '0;
        tick(3);
        chk("R4 falling change messages", {31'd0, msg_valid}, 32'd1);
        ack_once();
        rd(OFF_REQ, v);  chk("R4 falling sets request", v, 32'h008);
        rd(OFF_PEND, v);
        tick(2);
        chk("R4 single message per change", {31'd0, msg_valid}, 32'd0);
    endtask

    task automatic t_unmask_asserted();
        logic [31:0] v;
        wr(OFF_MASK, 32'h000);
        irq_in = 11'h400;
        tick(4);
        wr(OFF_MASK, 32'h400);
        tick(4);
        chk("R5 no message on unmask", {31'd0, msg_valid}, 32'd0);
        rd(OFF_REQ, v);   chk("R5 no request on unmask", v, 32'd0);
        rd(OFF_LEVEL, v); chk("R5 level shows held line", v, 32'h400);
        wr(OFF_MASK, 32'h000);
        irq_in = '0;
        tick(4);
    endtask

    task automatic t_impl();
        logic [31:0] v;
        wr(OFF_MASK, 32'h7FF);
        irq_in = 11'h200;
        tick(4);
        chk("R2 line 9 launches nothing", {31'd0, msg_valid}, 32'd0);
        rd(OFF_PEND, v); chk("R2 line 9 pending", v, 32'h200);
        rd(OFF_REQ, v);  chk("R2 line 9 no request", v, 32'd0);
        irq_in = '0;
        tick(4);
        rd(OFF_PEND, v); chk("R2 line 9 fall pending", v, 32'h200);
    endtask

    task automatic t_merge();
        logic [31:0] v;
        irq_in = 11'h001;
        tick(3);
        chk("R7 first message", {31'd0, msg_valid}, 32'd1);
        irq_in = 11'h003;
        tick(3);
        irq_in = 11'h007;
        tick(3);
        chk("R7 still first message", {31'd0, msg_valid}, 32'd1);
        ack_once();
        chk("R7 gap after ack", {31'd0, msg_valid}, 32'd0);
        tick(1);
        chk("R7 follow-up raised", {31'd0, msg_valid}, 32'd1);
        ack_once();
        tick(4);
        chk("R7 only one follow-up", {31'd0, msg_valid}, 32'd0);
        rd(OFF_REQ, v);  chk("R7 merged requests", v, 32'h007);
        rd(OFF_PEND, v);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(OFF_CTRL, 32'd0);
        irq_in = 11'h017;
        tick(4);
        chk("R9 disabled no message", {31'd0, msg_valid}, 32'd0);
        rd(OFF_PEND, v); chk("R9 pending still latches", v, 32'h010);
        wr(OFF_CTRL, 32'd1);
        tick(4);
        chk("R9 enable alone no message", {31'd0, msg_valid}, 32'd0);
        rd(OFF_REQ, v);  chk("R9 request latched while disabled", v, 32'h010);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(OFF_TARGET, 32'hCAFE_0001);
        rd(OFF_TARGET, v); chk("R10 target readback", v, 32'hCAFE_0001);
        wr(OFF_MASK, 32'hFFFF_F3A5);
        rd(OFF_MASK, v);   chk("R10 mask readback", v, 32'h3A5);
        wr(OFF_REQ, 32'hFFFF_FFFF);
        rd(OFF_REQ, v);    chk("R10 request write ignored", v, 32'd0);
        wr(OFF_PEND, 32'hFFFF_FFFF);
        rd(OFF_PEND, v);   chk("R10 pending write ignored", v, 32'd0);
        wr(OFF_LEVEL, 32'hFFFF_FFFF);
        rd(OFF_LEVEL, v);  chk("R10 level write ignored", v, 32'h017);
        rd(12'h030, v);    chk("R10 unmapped reads zero", v, 32'd0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_level();
        t_message();
        t_unmask_asserted();
        t_impl();
        t_merge();
        t_disable();
        t_map();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule